// File: doc/BRIEF.md
# Spectral-Inversion Audio Scrambler

This block scrambles or unscrambles a stereo audio stream by inverting its spectrum. Each incoming signed 16-bit sample is multiplied by a cosine carrier, which mirrors the audio band around half the carrier frequency. A second pass over an already inverted stream puts the band back where it was, so a single instance serves both as scrambler and as descrambler.

The block runs in the audio clock domain. A one-cycle sample strobe marks each new stereo sample. The carrier is a numerically controlled oscillator: a 32-bit phase register advances by a programmable step on every strobe. The top 8 bits of that register select an entry in a 256-entry cosine table. The step is chosen so that the carrier lies above the audio bandwidth. Both channels use the same carrier sample. Each product is scaled back to 16 bits and clipped. The result is registered, so that a downstream sink that latches on the next strobe sees a stable value.

Top module: `voice_scrambler`

## Requirements
- R1: A synchronous active-high `rst` clears both outputs to 0 and the carrier phase to 0. The first strobe after reset therefore uses table index 0.
- R2: While `smp_en` is low, `out_l` and `out_r` keep their values.
- R3: On a clock edge with `smp_en` high, each output becomes clip((x·c) >>> 15) from the next cycle on. Here x is the channel input, c is table entry `phase[31:24]`, and the shift is arithmetic.
- R4: The phase register adds `phase_inc` (modulo 2^32) once per strobe and at no other time. Strobe number n after reset (counting from 0) uses phase n·inc.
- R5: Both channels use the same carrier value within a strobe, so equal inputs give equal outputs.
- R6: Table entry k is the rounded value of 32767·cos(2πk/256), in Q1.15. With a step of 0 the carrier stays at +32767.
- R7: A step of 2^31 alternates the table index between 0 and 128. The carrier is then +32767 on even strobes and −32767 on odd strobes.
- R8: Results are clipped to −32768..32767 and never wrap. Full-scale negative input times the negative peak gives 32767.
- R9: A change of `phase_inc` has no effect on the sample of the current strobe. It only alters the phase used from the next strobe on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | One-cycle sample strobe |
| phase_inc | input | 32 | Carrier phase step per sample |
| in_l | input | 16 | Left input sample, signed |
| in_r | input | 16 | Right input sample, signed |
| out_l | output | 16 | Left modulated sample, signed |
| out_r | output | 16 | Right modulated sample, signed |

## Verification
The assertions assume that `smp_en` is a single-cycle pulse separated by idle cycles. They also assume that `phase_inc` and the inputs are steady during the strobe cycle. The bench drives every strobe as one high cycle followed by at least one low cycle. It changes inputs and the step only at falling clock edges. The hold property is therefore checked over real idle gaps, and the phase-step property always compares against the step that was sampled.

// File: rtl/scr_pkg.sv
package scr_pkg;
    localparam int SMP_W   = 16;
    localparam int PH_W    = 32;
    localparam int LUT_AW  = 8;
    localparam int CAR_FRAC = 15;
    localparam int N_CH    = 2;
    localparam int PROD_W  = 2 * SMP_W;

    typedef logic signed [SMP_W-1:0] smp_t;
    typedef logic [PH_W-1:0]         phase_t;
endpackage

// File: rtl/scr_cos_rom.sv
module scr_cos_rom
    import scr_pkg::*;
#(
    parameter int AW   = LUT_AW,
    parameter int DW   = SMP_W,
    parameter int FRAC = CAR_FRAC
) (
    input  logic [AW-1:0]        idx,
    output logic signed [DW-1:0] car
);
    localparam int DEPTH = 1 << AW;
    localparam real TWO_PI = 6.283185307179586;
    localparam real PEAK   = (2.0 ** FRAC) - 1.0;

    logic signed [DW-1:0] tbl [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_ent
        localparam real ANG = TWO_PI * k / DEPTH;
        localparam int  VAL = int'($cos(ANG) * PEAK);
        assign tbl[k] = VAL[DW-1:0];
    end

    assign car = tbl[idx];
endmodule

// File: rtl/scr_nco.sv
module scr_nco
    import scr_pkg::*;
#(
    parameter int PW = PH_W,
    parameter int AW = LUT_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic [PW-1:0] inc,
    output logic [PW-1:0] phase,
    output logic [AW-1:0] idx
);
    always_ff @(posedge clk) begin
        if (rst)       phase <= '0;
        else if (step) phase <= phase + inc;
    end

    assign idx = phase[PW-1 -: AW];
endmodule

// File: rtl/scr_modsat.sv
module scr_modsat
    import scr_pkg::*;
#(
    parameter int DW   = SMP_W,
    parameter int FRAC = CAR_FRAC
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic signed [DW-1:0] x,
    input  logic signed [DW-1:0] c,
    output logic signed [DW-1:0] y
);
    localparam int PW = 2 * DW;
    localparam logic signed [PW-1:0] HI = PW'((1 <<< (DW-1)) - 1);
    localparam logic signed [PW-1:0] LO = -PW'(1 <<< (DW-1));

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] scaled;
    logic signed [DW-1:0] clip;

    always_comb begin
        prod   = PW'(x) * PW'(c);
        scaled = prod >>> FRAC;
        if (scaled > HI)      clip = HI[DW-1:0];
        else if (scaled < LO) clip = LO[DW-1:0];
        else                  clip = scaled[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)     y <= '0;
        else if (en) y <= clip;
    end
endmodule

// File: rtl/voice_scrambler.sv
module voice_scrambler
    import scr_pkg::*;
#(
    parameter int DW  = SMP_W,
    parameter int PW  = PH_W,
    parameter int AW  = LUT_AW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_en,
    input  logic [PW-1:0]        phase_inc,
    input  logic signed [DW-1:0] in_l,
    input  logic signed [DW-1:0] in_r,
    output logic signed [DW-1:0] out_l,
    output logic signed [DW-1:0] out_r
);
    localparam int NC = N_CH;

    logic [PW-1:0]        phase_w;
    logic [AW-1:0]        idx_w;
    logic signed [DW-1:0] car_w;
    logic signed [DW-1:0] xin  [NC];
    logic signed [DW-1:0] yout [NC];

    scr_nco #(.PW(PW), .AW(AW)) u_nco (
        .clk(clk), .rst(rst), .step(smp_en), .inc(phase_inc),
        .phase(phase_w), .idx(idx_w)
    );

    scr_cos_rom #(.AW(AW), .DW(DW), .FRAC(CAR_FRAC)) u_rom (
        .idx(idx_w), .car(car_w)
    );

    assign xin[0] = in_l;
    assign xin[1] = in_r;

    for (genvar ch = 0; ch < NC; ch++) begin : g_ch
        scr_modsat #(.DW(DW), .FRAC(CAR_FRAC)) u_mod (
            .clk(clk), .rst(rst), .en(smp_en),
            .x(xin[ch]), .c(car_w), .y(yout[ch])
        );
    end

    assign out_l = yout[0];
    assign out_r = yout[1];
endmodule

// File: rtl/scr_chk.sv
module scr_chk #(
    parameter int DW = 16,
    parameter int PW = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 smp_en,
    input logic [PW-1:0]        phase_inc,
    input logic signed [DW-1:0] in_l,
    input logic signed [DW-1:0] in_r,
    input logic signed [DW-1:0] out_l,
    input logic signed [DW-1:0] out_r,
    input logic [PW-1:0]        phase
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (out_l == '0 && out_r == '0 && phase == '0));

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !smp_en |=> ($stable(out_l) && $stable(out_r)));

    a_r4_phase_step: assert property (@(posedge clk) disable iff (rst)
        smp_en |=> (phase == $past(phase) + $past(phase_inc)));

    a_r4_phase_idle: assert property (@(posedge clk) disable iff (rst)
        !smp_en |=> $stable(phase));

    a_r5_same_carrier: assert property (@(posedge clk) disable iff (rst)
        (smp_en && in_l == in_r) |=> (out_l == out_r));

    a_r3_zero_in: assert property (@(posedge clk) disable iff (rst)
        (smp_en && in_l == '0) |=> (out_l == '0));
endmodule

bind voice_scrambler scr_chk #(.DW(DW), .PW(PW)) u_chk (
    .clk(clk), .rst(rst), .smp_en(smp_en), .phase_inc(phase_inc),
    .in_l(in_l), .in_r(in_r), .out_l(out_l), .out_r(out_r),
    .phase(phase_w)
);

// File: tb/tb_voice_scrambler.sv
module tb_voice_scrambler;
    logic               clk = 1'b0;
    logic               rst;
    logic               smp_en;
    logic [31:0]        phase_inc;
    logic signed [15:0] in_l, in_r;
    logic signed [15:0] out_l, out_r;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] m_phase;

    always #4 clk = ~clk;

    voice_scrambler dut (
        .clk(clk), .rst(rst), .smp_en(smp_en), .phase_inc(phase_inc),
        .in_l(in_l), .in_r(in_r), .out_l(out_l), .out_r(out_r)
    );

    function automatic int car_of(input int k);
        real a;
        a = 6.283185307179586 * k / 256.0;
        return int'($cos(a) * 32767.0);
    endfunction

    function automatic int mod_of(input int x, input int c);
        longint p;
        longint s;
        p = longint'(x) * longint'(c);
        s = p >>> 15;
        if (s > 32767)  s = 32767;
        if (s < -32768) s = -32768;
        return int'(s);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; smp_en = 1'b0; phase_inc = '0; in_l = '0; in_r = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_phase = '0;
    endtask

    task automatic pulse(input int xl, input int xr, input string req);
        int c;
        @(negedge clk);
        in_l = 16'(xl); in_r = 16'(xr); smp_en = 1'b1;
        c = car_of(int'(m_phase[31:24]));
        @(negedge clk);
        smp_en = 1'b0;
        chk(req, int'(out_l), mod_of(xl, c));
        chk(req, int'(out_r), mod_of(xr, c));
        m_phase = m_phase + phase_inc;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", int'(out_l), 0);
        chk("R1", int'(out_r), 0);
        phase_inc = 32'h1234_5678;
        pulse(1000, -1000, "R1");
        do_reset();
        chk("R1", int'(out_l), 0);
    endtask

    task automatic t_dc();
        do_reset();
        phase_inc = 32'd0;
        pulse(20000, -20000, "R6");
        pulse(-32768, 32767, "R6");
        chk("R6", int'(out_l), mod_of(-32768, 32767));
    endtask

    task automatic t_nyquist();
        do_reset();
        phase_inc = 32'h8000_0000;
        for (int i = 0; i < 4; i++) begin
            pulse(12345, 12345, "R7");
            chk("R7", int'(out_l), (i % 2 == 0) ? mod_of(12345, 32767)
                                                : mod_of(12345, -32767));
        end
    endtask

    task automatic t_hold();
        logic signed [15:0] keep_l, keep_r;
        do_reset();
        phase_inc = 32'h0400_0000;
        pulse(7777, -5555, "R2");
        keep_l = out_l; keep_r = out_r;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            in_l = 16'(i * 3001); in_r = -16'(i * 77);
        end
        @(negedge clk);
        chk("R2", int'(out_l), int'(keep_l));
        chk("R2", int'(out_r), int'(keep_r));
        pulse(100, 100, "R4");
    endtask

    task automatic t_sat();
        do_reset();
        phase_inc = 32'h8000_0000;
        pulse(0, 0, "R8");
        pulse(-32768, 32767, "R8");
        chk("R8", int'(out_l), 32767);
        chk("R8", int'(out_r), -32767);
    endtask

    task automatic t_sweep();
        logic [15:0] lf;
        do_reset();
        phase_inc = 32'h0D5C_28F6;
        lf = 16'hACE1;
        for (int i = 0; i < 40; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            pulse(int'($signed(lf)), int'($signed(~lf)), "R3");
            if (i % 7 == 3) begin
                @(negedge clk);
                @(negedge clk);
            end
        end
        pulse(-4321, -4321, "R5");
        chk("R5", int'(out_l), int'(out_r));
    endtask

    task automatic t_inc_change();
        do_reset();
        phase_inc = 32'h4000_0000;
        pulse(16384, 1, "R9");
        phase_inc = 32'h2000_0000;
        pulse(16384, 1, "R9");
        chk("R9", int'(out_l), mod_of(16384, car_of(64)));
        pulse(16384, 1, "R9");
        chk("R9", int'(out_l), mod_of(16384, car_of(96)));
    endtask

    initial begin
        rst = 1'b1; smp_en = 1'b0; phase_inc = '0; in_l = '0; in_r = '0;
        m_phase = '0;
        t_reset();
        t_dc();
        t_nyquist();
        t_hold();
        t_sat();
        t_sweep();
        t_inc_change();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule